// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits on the receive side of an Ethernet MAC. It watches the first six bytes of each incoming frame, which carry the destination address. One clock after the last of them it states whether the frame is to be kept. The bytes arrive from the receive path one per clock at most, marked by a valid qualifier. A start-of-frame strobe marks the first byte. Configuration inputs supply the station's own address, a 64-bit multicast hash table and the mode bits.

The filter works in layers. The base filter accepts three kinds of frame: an exact match on the station address, broadcast frames (unless these are disabled), and multicast frames that hit the hash table. A pass-all-multicast mode widens the base filter to every multicast frame. Two override modes then accept every frame: promiscuous mode, and a pass-all mode whose purpose is to report what the base filter would have decided. In every mode the block reports the match type as separate flags: perfect hit, hash hit, broadcast and multicast. A further flag carries the base filter's verdict.

Frame buffering, CRC checking of the frame and the media interface belong to other blocks. The downstream buffer uses `res_done` as the moment to commit or discard the frame.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `res_done`, `res_accept`, `res_match` and all four match flags are 0.
- R2: The first destination byte is the one presented with `sof` and `byte_valid` both high. Each following byte is one cycle with `byte_valid` high. `res_done` is high for exactly the one cycle after the clock edge that captures the sixth byte. Further bytes before the next `sof` produce no second `res_done` and change no result.
- R3: The destination bytes are compared in order of arrival with `cfg_station_addr[7:0]` (first byte) up to `cfg_station_addr[47:40]` (sixth byte). When all six bytes are equal, `flag_perfect` is 1 and the frame is accepted.
- R4: The hash index is bits [31:26] of a CRC register. The register starts at all ones and takes the 48 address bits, each byte least significant bit first. It uses the reflected polynomial 0xEDB88320 and no final inversion. `flag_hash` is 1 when the address is multicast and `cfg_hash_table[index]` is 1, and such a frame is accepted.
- R5: The group bit is bit 0 of the first byte. `flag_bcast` is 1 when all 48 bits are ones. `flag_mcast` is 1 when the group bit is set and the address is not broadcast.
- R6: A broadcast frame is accepted by the base filter unless `cfg_bcast_off` is 1. In that case it is dropped, provided no other mode accepts it.
- R7: With `cfg_all_mcast` set, every frame with `flag_mcast` set is accepted, whatever the hash table holds.
- R8: With `cfg_promisc` set, every frame is accepted, and the match flags are still reported.
- R9: With `cfg_pass_status` set, every frame is accepted, and `res_match` gives the base filter's verdict (R3, R4, R6, R7).
- R10: A unicast address that differs from the station address, with no override mode set, gives `res_accept` = 0 and `res_match` = 0.
- R11: A `sof` during an incomplete address discards the bytes collected so far. The decision then uses only the six bytes that start at the new `sof`.
- R12: The results hold their values from `res_done` until the next `sof`, which clears them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Start-of-frame strobe, restarts address collection |
| byte_valid | input | 1 | Qualifies `byte_data` |
| byte_data | input | 8 | Destination address byte from the receive path |
| cfg_station_addr | input | 48 | Station address, first byte in bits [7:0] |
| cfg_hash_table | input | 64 | Multicast hash table, one bit per bin |
| cfg_bcast_off | input | 1 | Drop broadcast in the base filter |
| cfg_all_mcast | input | 1 | Accept every multicast frame |
| cfg_promisc | input | 1 | Accept every frame |
| cfg_pass_status | input | 1 | Accept every frame and report the base verdict |
| res_done | output | 1 | One-cycle strobe when a decision is ready |
| res_accept | output | 1 | Keep the frame |
| res_match | output | 1 | Base filter verdict |
| flag_perfect | output | 1 | Station address match |
| flag_hash | output | 1 | Multicast hash hit |
| flag_bcast | output | 1 | Broadcast destination |
| flag_mcast | output | 1 | Multicast, non-broadcast destination |

## Verification
On every cycle the assertions check four things: the timing of `res_done` against a byte count kept from the ports, that both override modes force acceptance, that an accepted frame always has a cause among the flags and mode bits, and that results stay put between decisions. Broadcast and multicast are also checked to be exclusive. The assertions cannot show that the compare takes the bytes in the correct order, that the CRC hash lands in the correct bin, or that a restarted address discards its old bytes. Only the bench's scenarios can show those, because each one needs a known address whose expected result the bench works out by itself.

// File: rtl/raf_pkg.sv
package raf_pkg;

   localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;
   localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

   typedef struct packed {
      logic perfect;
      logic hash;
      logic bcast;
      logic mcast;
      logic match;
   } raf_flags_t;

   // advance a reflected CRC-32 by one byte, least significant bit first
   function automatic logic [31:0] crc_step_byte(input logic [31:0] c_in, input logic [7:0] d);
      logic [31:0] c;
      c = c_in;
      for (int b = 0; b < 8; b++) begin
         if (c[0] ^ d[b]) c = (c >> 1) ^ CRC_POLY_REFL;
         else             c = c >> 1;
      end
      return c;
   endfunction

endpackage

// File: rtl/raf_capture.sv
module raf_capture #(
   parameter int N_BYTES = 6,
   localparam int CW = $clog2(N_BYTES + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sof,
   input  logic                 byte_valid,
   input  logic [7:0]           byte_data,
   output logic [N_BYTES*8-1:0] addr_now,
   output logic                 take,
   output logic                 last
);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] slot_idx;

   assign slot_idx = sof ? '0 : cnt_q;
   assign take     = byte_valid && (sof || (cnt_q < CW'(N_BYTES)));
   assign last     = take && (slot_idx == CW'(N_BYTES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (sof)     cnt_q <= byte_valid ? CW'(1) : '0;
      else if (take)    cnt_q <= cnt_q + CW'(1);
   end

   for (genvar k = 0; k < N_BYTES; k++) begin : g_slot
      logic [7:0] slot_q;
      logic       hit;
      assign hit = take && (slot_idx == CW'(k));
      always_ff @(posedge clk) begin
         if (!rst_n)        slot_q <= '0;
         else if (hit)      slot_q <= byte_data;
         else if (sof)      slot_q <= '0;
      end
      assign addr_now[k*8 +: 8] = hit ? byte_data : slot_q;
   end

endmodule

// File: rtl/raf_crc.sv
module raf_crc
   import raf_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sof,
   input  logic        take,
   input  logic [7:0]  byte_data,
   output logic [31:0] crc_next
);

   logic [31:0] crc_q;
   logic [31:0] crc_base;

   assign crc_base = sof ? CRC_SEED : crc_q;
   assign crc_next = crc_step_byte(crc_base, byte_data);

   always_ff @(posedge clk) begin
      if (!rst_n)          crc_q <= CRC_SEED;
      else if (take)       crc_q <= crc_next;
      else if (sof)        crc_q <= CRC_SEED;
   end

endmodule

// File: rtl/raf_decide.sv
module raf_decide
   import raf_pkg::*;
#(
   parameter int N_BYTES = 6,
   parameter int HASH_BITS = 6,
   parameter bit HASH_FROM_TOP = 1'b1,
   localparam int AW = N_BYTES * 8,
   localparam int TW = 1 << HASH_BITS
) (
   input  logic [AW-1:0]  addr,
   input  logic [31:0]    crc,
   input  logic [AW-1:0]  station,
   input  logic [TW-1:0]  table_bits,
   input  logic           bcast_off,
   input  logic           all_mcast,
   output raf_flags_t     flags
);

   logic [HASH_BITS-1:0] idx;

   if (HASH_FROM_TOP) begin : g_idx_top
      assign idx = crc[31 -: HASH_BITS];
   end else begin : g_idx_low
      assign idx = crc[HASH_BITS-1:0];
   end

   always_comb begin
      flags.perfect = (addr == station);
      flags.bcast   = &addr;
      flags.mcast   = addr[0] && !flags.bcast;
      flags.hash    = flags.mcast && table_bits[idx];
      flags.match   = flags.perfect
                    || (flags.bcast && !bcast_off)
                    || (flags.mcast && (all_mcast || flags.hash));
   end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
   import raf_pkg::*;
#(
   parameter int ADDR_BYTES = 6,
   parameter int HASH_BITS = 6,
   parameter bit HASH_FROM_TOP = 1'b1,
   localparam int AW = ADDR_BYTES * 8,
   localparam int TW = 1 << HASH_BITS
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sof,
   input  logic          byte_valid,
   input  logic [7:0]    byte_data,
   input  logic [AW-1:0] cfg_station_addr,
   input  logic [TW-1:0] cfg_hash_table,
   input  logic          cfg_bcast_off,
   input  logic          cfg_all_mcast,
   input  logic          cfg_promisc,
   input  logic          cfg_pass_status,
   output logic          res_done,
   output logic          res_accept,
   output logic          res_match,
   output logic          flag_perfect,
   output logic          flag_hash,
   output logic          flag_bcast,
   output logic          flag_mcast
);

   if (ADDR_BYTES < 1) begin : g_bad_bytes
      $error("ADDR_BYTES must be at least 1");
   end
   if (HASH_BITS < 1 || HASH_BITS > 12) begin : g_bad_hash
      $error("HASH_BITS must lie in 1..12");
   end

   logic [AW-1:0] addr_now;
   logic          take;
   logic          last;
   logic [31:0]   crc_next;
   raf_flags_t    flags;

   raf_capture #(.N_BYTES(ADDR_BYTES)) u_capture (
      .clk(clk), .rst_n(rst_n), .sof(sof), .byte_valid(byte_valid),
      .byte_data(byte_data), .addr_now(addr_now), .take(take), .last(last)
   );

   raf_crc u_crc (
      .clk(clk), .rst_n(rst_n), .sof(sof), .take(take),
      .byte_data(byte_data), .crc_next(crc_next)
   );

   raf_decide #(
      .N_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS), .HASH_FROM_TOP(HASH_FROM_TOP)
   ) u_decide (
      .addr(addr_now), .crc(crc_next), .station(cfg_station_addr),
      .table_bits(cfg_hash_table), .bcast_off(cfg_bcast_off),
      .all_mcast(cfg_all_mcast), .flags(flags)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_done     <= 1'b0;
         res_accept   <= 1'b0;
         res_match    <= 1'b0;
         flag_perfect <= 1'b0;
         flag_hash    <= 1'b0;
         flag_bcast   <= 1'b0;
         flag_mcast   <= 1'b0;
      end else begin
         res_done <= last;
         if (last) begin
            res_accept   <= cfg_promisc || cfg_pass_status || flags.match;
            res_match    <= flags.match;
            flag_perfect <= flags.perfect;
            flag_hash    <= flags.hash;
            flag_bcast   <= flags.bcast;
            flag_mcast   <= flags.mcast;
         end else if (sof) begin
            res_accept   <= 1'b0;
            res_match    <= 1'b0;
            flag_perfect <= 1'b0;
            flag_hash    <= 1'b0;
            flag_bcast   <= 1'b0;
            flag_mcast   <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/raf_checker.sv
module raf_checker #(
   parameter int ADDR_BYTES = 6,
   parameter int HASH_BITS = 6,
   localparam int AW = ADDR_BYTES * 8,
   localparam int TW = 1 << HASH_BITS,
   localparam int CW = $clog2(ADDR_BYTES + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sof,
   input logic          byte_valid,
   input logic [7:0]    byte_data,
   input logic [AW-1:0] cfg_station_addr,
   input logic [TW-1:0] cfg_hash_table,
   input logic          cfg_bcast_off,
   input logic          cfg_all_mcast,
   input logic          cfg_promisc,
   input logic          cfg_pass_status,
   input logic          res_done,
   input logic          res_accept,
   input logic          res_match,
   input logic          flag_perfect,
   input logic          flag_hash,
   input logic          flag_bcast,
   input logic          flag_mcast
);

   logic [CW-1:0] seen_q;
   logic          final_byte;

   assign final_byte = byte_valid &&
                       (sof ? (ADDR_BYTES == 1) : (seen_q == CW'(ADDR_BYTES - 1)));

   always_ff @(posedge clk) begin
      if (!rst_n)                                   seen_q <= '0;
      else if (sof)                                 seen_q <= byte_valid ? CW'(1) : '0;
      else if (byte_valid && seen_q < CW'(ADDR_BYTES)) seen_q <= seen_q + CW'(1);
   end

   AST_DONE_TIMING: assert property (@(posedge clk) disable iff (!rst_n) res_done == $past(final_byte)); // R2
   AST_PROMISC_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (res_done && $past(cfg_promisc)) |-> res_accept); // R8
   AST_PASS_STATUS_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (res_done && $past(cfg_pass_status)) |-> res_accept); // R9
   AST_BCAST_MCAST_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(flag_bcast && flag_mcast)); // R5
   AST_ACCEPT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (res_done && res_accept) |-> ($past(cfg_promisc) || $past(cfg_pass_status) || flag_perfect ||
                                    (flag_bcast && !$past(cfg_bcast_off)) ||
                                    (flag_mcast && (flag_hash || $past(cfg_all_mcast))))); // R10
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!res_done && !$past(sof)) |-> ($stable(res_accept) && $stable(res_match) && $stable(flag_perfect))); // R12

endmodule

bind rx_addr_filter raf_checker #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS)) u_raf_checker (.*);

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sof = 1'b0;
   logic        byte_valid = 1'b0;
   logic [7:0]  byte_data = '0;
   logic [47:0] cfg_station_addr = 48'h6655_4433_2210;
   logic [63:0] cfg_hash_table = '0;
   logic        cfg_bcast_off = 1'b0;
   logic        cfg_all_mcast = 1'b0;
   logic        cfg_promisc = 1'b0;
   logic        cfg_pass_status = 1'b0;
   logic        res_done, res_accept, res_match;
   logic        flag_perfect, flag_hash, flag_bcast, flag_mcast;

   int n_checks = 0;
   int n_bad = 0;

   localparam logic [47:0] STATION = 48'h6655_4433_2210;
   localparam logic [47:0] OTHER   = 48'h6655_4433_2212;
   localparam logic [47:0] BCAST   = 48'hFFFF_FFFF_FFFF;
   localparam logic [47:0] MC_A    = 48'h0100_005E_0001;
   localparam logic [47:0] MC_B    = 48'h2345_6789_AB33;

   always #2 clk = ~clk;

   rx_addr_filter u_rx_addr_filter (.*);

   function automatic logic [5:0] hash_of(input logic [47:0] a);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 0; i < 48; i++) begin
         if (c[0] != a[i]) c = {1'b0, c[31:1]} ^ 32'hEDB8_8320;
         else              c = {1'b0, c[31:1]};
      end
      return c[31:26];
   endfunction

   task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   // drive six bytes starting with sof; return at the negedge where res_done is expected
   task automatic send_addr(input logic [47:0] a);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         sof = (k == 0);
         byte_valid = 1'b1;
         byte_data = a[k*8 +: 8];
      end
      @(negedge clk);
      sof = 1'b0;
      byte_valid = 1'b0;
   endtask

   task automatic expect_res(input string tag, input logic acc, input logic mt,
                             input logic pf, input logic hs, input logic bc, input logic mc);
      check({tag, " done"},    res_done,     1'b1);
      check({tag, " accept"},  res_accept,   acc);
      check({tag, " match"},   res_match,    mt);
      check({tag, " perfect"}, flag_perfect, pf);
      check({tag, " hash"},    flag_hash,    hs);
      check({tag, " bcast"},   flag_bcast,   bc);
      check({tag, " mcast"},   flag_mcast,   mc);
   endtask

   task automatic t_reset();
      check("R1 done after reset", res_done, 1'b0);
      check("R1 accept after reset", res_accept, 1'b0);
      check("R1 match after reset", res_match, 1'b0);
      check("R1 flags after reset", {flag_perfect, flag_hash, flag_bcast, flag_mcast}, 4'h0);
   endtask

   task automatic t_perfect();
      send_addr(STATION);
      expect_res("R3 station", 1, 1, 1, 0, 0, 0);
      @(negedge clk);
      check("R2 done single pulse", res_done, 1'b0);
      // R12: held after done
      check("R12 accept held", res_accept, 1'b1);
   endtask

   task automatic t_extra_bytes();
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         byte_valid = 1'b1;
         byte_data = 8'hFF;
         @(negedge clk);
         byte_valid = 1'b0;
         check("R2 extra byte no done", res_done, 1'b0);
      end
      check("R2 extra bytes keep perfect", flag_perfect, 1'b1);
      @(negedge clk);
      sof = 1'b1;
      @(negedge clk);
      sof = 1'b0;
      check("R12 sof clears accept", res_accept, 1'b0);
      check("R12 sof clears perfect", flag_perfect, 1'b0);
   endtask

   task automatic t_miss();
      send_addr(OTHER);
      expect_res("R10 unicast miss", 0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_bcast();
      send_addr(BCAST);
      expect_res("R6 bcast on", 1, 1, 0, 0, 1, 0);
      cfg_bcast_off = 1'b1;
      send_addr(BCAST);
      expect_res("R6 bcast off", 0, 0, 0, 0, 1, 0);
      cfg_bcast_off = 1'b0;
   endtask

   task automatic t_hash();
      logic hb;
      cfg_hash_table = 64'd1 << hash_of(MC_A);
      send_addr(MC_A);
      expect_res("R4 hash hit", 1, 1, 0, 1, 0, 1);
      hb = cfg_hash_table[hash_of(MC_B)];
      send_addr(MC_B);
      expect_res("R4 hash other", hb, hb, 0, hb, 0, 1);
      cfg_hash_table = ~(64'd1 << hash_of(MC_A));
      send_addr(MC_A);
      expect_res("R4 hash bin clear", 0, 0, 0, 0, 0, 1);
      // R5: group bit only in the first byte
      send_addr(48'h0100_0000_0000);
      expect_res("R5 group bit first byte", 0, 0, 0, 0, 0, 0);
      cfg_hash_table = '0;
   endtask

   task automatic t_all_mcast();
      cfg_all_mcast = 1'b1;
      send_addr(MC_B);
      expect_res("R7 all mcast", 1, 1, 0, 0, 0, 1);
      send_addr(OTHER);
      expect_res("R7 unicast still dropped", 0, 0, 0, 0, 0, 0);
      cfg_all_mcast = 1'b0;
   endtask

   task automatic t_promisc();
      cfg_promisc = 1'b1;
      send_addr(OTHER);
      expect_res("R8 promisc unicast", 1, 0, 0, 0, 0, 0);
      send_addr(STATION);
      expect_res("R8 promisc station", 1, 1, 1, 0, 0, 0);
      cfg_promisc = 1'b0;
   endtask

   task automatic t_pass_status();
      cfg_pass_status = 1'b1;
      send_addr(OTHER);
      expect_res("R9 pass miss", 1, 0, 0, 0, 0, 0);
      cfg_bcast_off = 1'b1;
      send_addr(BCAST);
      expect_res("R9 pass bcast off", 1, 0, 0, 0, 1, 0);
      cfg_bcast_off = 1'b0;
      send_addr(BCAST);
      expect_res("R9 pass bcast", 1, 1, 0, 0, 1, 0);
      cfg_pass_status = 1'b0;
   endtask

   task automatic t_restart();
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         sof = (k == 0);
         byte_valid = 1'b1;
         byte_data = OTHER[k*8 +: 8] ^ 8'h5A;
      end
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         if (res_done) check("R11 no early done", res_done, 1'b0);
         sof = (k == 0);
         byte_valid = 1'b1;
         byte_data = STATION[k*8 +: 8];
      end
      @(negedge clk);
      sof = 1'b0;
      byte_valid = 1'b0;
      expect_res("R11 restart", 1, 1, 1, 0, 0, 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_perfect();
      t_extra_bytes();
      t_miss();
      t_bcast();
      t_hash();
      t_all_mcast();
      t_promisc();
      t_pass_status();
      t_restart();
      repeat (3) @(negedge clk);
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end

   initial begin
      #(4 * 20000);
      n_checks++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end

endmodule